// File: doc/BRIEF.md
# Status Flag and Bit-Transfer Unit

This block owns an 8-bit processor status register and carries out the single-bit operations that act on it or route through it. Each flag can be set or cleared on its own. One transfer picks a bit of a register byte and places it in the T flag. Another writes T back into a chosen bit of a register byte. A third forces one bit of an I/O byte to zero. Every operation finishes in one clock.

The unit sits between an instruction decoder and the register file and I/O bus. The decoder presents a decoded operation code together with a 3-bit bit index, the source register byte and the current I/O byte. The unit returns the updated status register, plus a modified register byte and a modified I/O byte. Each modified byte has its own write-enable pulse, which tells the surrounding storage when to commit it.

The operation input is a valid-only stream: `op_valid` qualifies `op`, `bit_idx`, `reg_in` and `io_in` in the same cycle. The unit applies no back-pressure. It accepts one operation on every clock edge where `op_valid` is high, so no ready signal exists and a producer may issue back-to-back without stalls.

Top module: `flag_bit_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the status register, `reg_out`, `io_out`, `reg_we` and `io_we` to 0, whatever the operation inputs carry.
- R2: Flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Operation code 0x08+p sets the flag at position p to 1, and no other status bit changes.
- R3: Operation code 0x10+p clears the flag at position p to 0, and no other status bit changes.
- R4: Operation code 0x01 (bit store) copies `reg_in[bit_idx]` into T (bit 6). No other status bit changes.
- R5: Operation code 0x02 (bit load) drives `reg_out` with `reg_in`, except that bit `bit_idx` takes the value T held before the edge. It pulses `reg_we` and leaves every flag unchanged.
- R6: Operation code 0x03 (I/O bit clear) drives `io_out` with `io_in`, except that bit `bit_idx` is 0. It pulses `io_we` for that one clock and leaves every flag unchanged.
- R7: `reg_we` is high only in the cycle after an accepted bit load. `io_we` is high only in the cycle after an accepted I/O bit clear. The two are never high together.
- R8: When `op_valid` is low, or the code is unassigned (0x00, 0x04 to 0x07, 0x18 to 0x1F), the status register, `reg_out` and `io_out` keep their values and neither write enable is asserted.
- R9: Every operation is accepted on the edge where it is presented, and its result is visible after that single edge. Consecutive operations issue with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies the operation inputs this cycle |
| op | input | 5 | Decoded operation code |
| bit_idx | input | 3 | Bit index 0 to 7 |
| reg_in | input | 8 | Source register byte |
| io_in | input | 8 | Current byte at the addressed I/O location |
| status | output | 8 | Status register |
| reg_out | output | 8 | Modified register byte |
| reg_we | output | 1 | Register write enable, one cycle |
| io_out | output | 8 | Modified I/O byte |
| io_we | output | 1 | I/O write enable, one cycle |

## Verification
A vector table runs through every set code and then every clear code, each starting from a status value in which the target flag has the opposite state. This separates a wrong bit position from a missing update. Bit store and bit load are run with T at both 0 and 1, against register bytes whose other bits are all 0 or all 1. A lost neighbour bit and a wrong index therefore produce different results. Directed cases cover an idle cycle that carries a bit-load code, reserved codes, back-to-back loads followed by an I/O clear (write-enable handover), setting an already-set flag, and a reset arriving mid-stream.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  // operation group lives in the two top bits of the code
  typedef enum logic [1:0] {
    GRP_MISC = 2'b00,
    GRP_SET  = 2'b01,
    GRP_CLR  = 2'b10,
    GRP_RSV  = 2'b11
  } grp_e;

  // selector values inside the misc group
  localparam int unsigned MISC_BST   = 1;
  localparam int unsigned MISC_BLD   = 2;
  localparam int unsigned MISC_IOCLR = 3;

  // status bit positions
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
  localparam int unsigned FLG_H = 5;
  localparam int unsigned FLG_T = 6;
  localparam int unsigned FLG_I = 7;

  typedef struct packed {
    logic bst;
    logic bld;
    logic ioclr;
  } xfer_t;
endpackage

// File: rtl/sfu_op_decode.sv
module sfu_op_decode
  import sfu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW),
  parameter int OW = IW + 2
) (
  input  logic          op_valid,
  input  logic [OW-1:0] op,
  output logic [DW-1:0] set_mask,
  output logic [DW-1:0] clr_mask,
  output xfer_t         xfer
);
  grp_e          grp;
  logic [IW-1:0] sel;

  assign grp = grp_e'(op[OW-1:OW-2]);
  assign sel = op[IW-1:0];

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign set_mask[i] = op_valid && (grp == GRP_SET) && (sel == IW'(i));
    assign clr_mask[i] = op_valid && (grp == GRP_CLR) && (sel == IW'(i));
  end

  always_comb begin
    xfer       = '0;
    xfer.bst   = op_valid && (grp == GRP_MISC) && (sel == IW'(MISC_BST));
    xfer.bld   = op_valid && (grp == GRP_MISC) && (sel == IW'(MISC_BLD));
    xfer.ioclr = op_valid && (grp == GRP_MISC) && (sel == IW'(MISC_IOCLR));
  end
endmodule

// File: rtl/sfu_bit_lane.sv
module sfu_bit_lane #(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] src_byte,
  input  logic [DW-1:0] io_byte,
  input  logic          t_in,
  output logic          picked,
  output logic [DW-1:0] ins_byte,
  output logic [DW-1:0] clr_byte
);
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign hit[i]      = (idx == IW'(i));
    assign ins_byte[i] = hit[i] ? t_in : src_byte[i];
    assign clr_byte[i] = hit[i] ? 1'b0 : io_byte[i];
  end

  assign picked = |(hit & src_byte);
endmodule

// File: rtl/sfu_status_reg.sv
module sfu_status_reg #(
  parameter int DW    = 8,
  parameter int T_POS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_mask,
  input  logic [DW-1:0] clr_mask,
  input  logic          t_load,
  input  logic          t_bit,
  output logic [DW-1:0] flags
);
  for (genvar i = 0; i < DW; i++) begin : g_flag
    if (i == T_POS) begin : g_t
      always_ff @(posedge clk) begin
        if (rst)              flags[i] <= 1'b0;
        else if (set_mask[i]) flags[i] <= 1'b1;
        else if (clr_mask[i]) flags[i] <= 1'b0;
        else if (t_load)      flags[i] <= t_bit;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)              flags[i] <= 1'b0;
        else if (set_mask[i]) flags[i] <= 1'b1;
        else if (clr_mask[i]) flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flag_bit_unit.sv
module flag_bit_unit
  import sfu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW),
  parameter int OW = IW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [OW-1:0] op,
  input  logic [IW-1:0] bit_idx,
  input  logic [DW-1:0] reg_in,
  input  logic [DW-1:0] io_in,
  output logic [DW-1:0] status,
  output logic [DW-1:0] reg_out,
  output logic          reg_we,
  output logic [DW-1:0] io_out,
  output logic          io_we
);
  logic [DW-1:0] set_mask;
  logic [DW-1:0] clr_mask;
  xfer_t         xfer;
  logic          picked;
  logic [DW-1:0] ins_byte;
  logic [DW-1:0] clr_byte;

  sfu_op_decode #(.DW(DW), .IW(IW), .OW(OW)) u_dec (
    .op_valid (op_valid),
    .op       (op),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .xfer     (xfer)
  );

  sfu_bit_lane #(.DW(DW), .IW(IW)) u_lane (
    .idx      (bit_idx),
    .src_byte (reg_in),
    .io_byte  (io_in),
    .t_in     (status[FLG_T]),
    .picked   (picked),
    .ins_byte (ins_byte),
    .clr_byte (clr_byte)
  );

  sfu_status_reg #(.DW(DW), .T_POS(FLG_T)) u_sreg (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .t_load   (xfer.bst),
    .t_bit    (picked),
    .flags    (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_out <= '0;
      reg_we  <= 1'b0;
      io_out  <= '0;
      io_we   <= 1'b0;
    end else begin
      reg_we <= xfer.bld;
      io_we  <= xfer.ioclr;
      if (xfer.bld)   reg_out <= ins_byte;
      if (xfer.ioclr) io_out  <= clr_byte;
    end
  end
endmodule

// File: rtl/flag_bit_unit_chk.sv
module flag_bit_unit_chk
  import sfu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW),
  parameter int OW = IW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [OW-1:0] op,
  input logic [IW-1:0] bit_idx,
  input logic [DW-1:0] reg_in,
  input logic [DW-1:0] io_in,
  input logic [DW-1:0] status,
  input logic [DW-1:0] reg_out,
  input logic          reg_we,
  input logic [DW-1:0] io_out,
  input logic          io_we
);
  localparam logic [OW-1:0] OP_BST   = OW'(MISC_BST);
  localparam logic [OW-1:0] OP_BLD   = OW'(MISC_BLD);
  localparam logic [OW-1:0] OP_IOCLR = OW'(MISC_IOCLR);
  localparam logic [DW-1:0] T_MASK   = DW'(1) << FLG_T;

  logic flag_op;
  assign flag_op = op_valid && (op[OW-1] ^ op[OW-2]);

  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flag_op |=> $countones(status ^ $past(status)) <= 1); // R2

  AST_BST_ONLY_T: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_BST) |=>
      (status[FLG_T] == $past(reg_in[bit_idx])) &&
      (((status ^ $past(status)) & ~T_MASK) == '0)); // R4

  AST_BLD_MERGE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_BLD) |=>
      reg_we && $stable(status) &&
      (((reg_out ^ $past(reg_in)) & ~(DW'(1) << $past(bit_idx))) == '0) &&
      (reg_out[$past(bit_idx)] == status[FLG_T])); // R5

  AST_IOCLR_BIT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_IOCLR) |=>
      io_we && $stable(status) && (io_out[$past(bit_idx)] == 1'b0)); // R6

  AST_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && io_we)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(status) && $stable(reg_out) && $stable(io_out)
                  && !reg_we && !io_we); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status == '0) && !reg_we && !io_we); // R1
endmodule

bind flag_bit_unit flag_bit_unit_chk #(.DW(DW), .IW(IW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op       (op),
  .bit_idx  (bit_idx),
  .reg_in   (reg_in),
  .io_in    (io_in),
  .status   (status),
  .reg_out  (reg_out),
  .reg_we   (reg_we),
  .io_out   (io_out),
  .io_we    (io_we)
);

// File: tb/tb_flag_bit_unit.sv
module tb_flag_bit_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [4:0] op;
  logic [2:0] bit_idx;
  logic [7:0] reg_in, io_in;
  logic [7:0] status, reg_out, io_out;
  logic       reg_we, io_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flag_bit_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .bit_idx(bit_idx),
    .reg_in(reg_in), .io_in(io_in), .status(status), .reg_out(reg_out),
    .reg_we(reg_we), .io_out(io_out), .io_we(io_we)
  );

  // {op, idx, reg_in, io_in, exp status, exp reg_out, exp reg_we, exp io_out, exp io_we}
  localparam int NV = 27;
  localparam logic [49:0] VEC [NV] = '{
    {5'h08, 3'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 8'h00, 1'b0},
    {5'h0F, 3'd0, 8'h00, 8'h00, 8'h81, 8'h00, 1'b0, 8'h00, 1'b0},
    {5'h09, 3'd0, 8'h00, 8'h00, 8'h83, 8'h00, 1'b0, 8'h00, 1'b0},
    {5'h10, 3'd0, 8'h00, 8'h00, 8'h82, 8'h00, 1'b0, 8'h00, 1'b0},
    {5'h01, 3'd3, 8'h08, 8'h00, 8'hC2, 8'h00, 1'b0, 8'h00, 1'b0},
    {5'h02, 3'd0, 8'hF0, 8'h00, 8'hC2, 8'hF1, 1'b1, 8'h00, 1'b0},
    {5'h01, 3'd0, 8'hFE, 8'h00, 8'h82, 8'hF1, 1'b0, 8'h00, 1'b0},
    {5'h02, 3'd7, 8'hFF, 8'h00, 8'h82, 8'h7F, 1'b1, 8'h00, 1'b0},
    {5'h03, 3'd5, 8'h00, 8'hFF, 8'h82, 8'h7F, 1'b0, 8'hDF, 1'b1},
    {5'h03, 3'd2, 8'hAA, 8'h04, 8'h82, 8'h7F, 1'b0, 8'h00, 1'b1},
    {5'h0D, 3'd0, 8'h00, 8'h00, 8'hA2, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h0C, 3'd0, 8'h00, 8'h00, 8'hB2, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h0B, 3'd0, 8'h00, 8'h00, 8'hBA, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h0A, 3'd0, 8'h00, 8'h00, 8'hBE, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h0E, 3'd0, 8'h00, 8'h00, 8'hFE, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h08, 3'd0, 8'h00, 8'h00, 8'hFF, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h17, 3'd0, 8'h00, 8'h00, 8'h7F, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h16, 3'd0, 8'h00, 8'h00, 8'h3F, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h15, 3'd0, 8'h00, 8'h00, 8'h1F, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h14, 3'd0, 8'h00, 8'h00, 8'h0F, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h13, 3'd0, 8'h00, 8'h00, 8'h07, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h12, 3'd0, 8'h00, 8'h00, 8'h03, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h11, 3'd0, 8'h00, 8'h00, 8'h01, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h01, 3'd7, 8'h80, 8'h00, 8'h41, 8'h7F, 1'b0, 8'h00, 1'b0},
    {5'h02, 3'd3, 8'h00, 8'h00, 8'h41, 8'h08, 1'b1, 8'h00, 1'b0},
    {5'h1F, 3'd0, 8'hFF, 8'hFF, 8'h41, 8'h08, 1'b0, 8'h00, 1'b0},
    {5'h10, 3'd0, 8'h00, 8'h00, 8'h40, 8'h08, 1'b0, 8'h00, 1'b0}
  };

  function automatic string tag_of(input logic [4:0] c);
    case (c[4:3])
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R8";
      default: case (c[2:0])
                 3'd1:    return "R4";
                 3'd2:    return "R5";
                 3'd3:    return "R6";
                 default: return "R8";
               endcase
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [4:0] c, input logic [2:0] i,
                       input logic [7:0] r, input logic [7:0] o);
    op_valid = v; op = c; bit_idx = i; reg_in = r; io_in = o;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op = '0; bit_idx = '0; reg_in = '0; io_in = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset status", status, 8'h00);
    chk("R1", "reset reg_out", reg_out, 8'h00);
    chk("R1", "reset io_out", io_out, 8'h00);
    chk("R1", "reset we", {6'd0, reg_we, io_we}, 8'h00);
    rst = 1'b0;

    // table walk, one operation per cycle (R9)
    for (int k = 0; k < NV; k++) begin
      logic [49:0] v;
      string t;
      v = VEC[k];
      t = tag_of(v[49:45]);
      drive(1'b1, v[49:45], v[44:42], v[41:34], v[33:26]);
      chk(t, "status", status, v[25:18]);
      chk(t, "reg_out", reg_out, v[17:10]);
      chk("R7", "reg_we", {7'd0, reg_we}, {7'd0, v[9]});
      chk(t, "io_out", io_out, v[8:1]);
      chk("R7", "io_we", {7'd0, io_we}, {7'd0, v[0]});
    end

    // idle cycle carrying a bit-load code: nothing moves (R8)
    drive(1'b0, 5'h02, 3'd0, 8'hFF, 8'h55);
    chk("R8", "idle status", status, 8'h40);
    chk("R8", "idle reg_out", reg_out, 8'h08);
    chk("R8", "idle we", {6'd0, reg_we, io_we}, 8'h00);
    chk("R8", "idle io_out", io_out, 8'h00);

    // reserved misc code (R8)
    drive(1'b1, 5'h04, 3'd1, 8'hFF, 8'hFF);
    chk("R8", "rsv status", status, 8'h40);
    chk("R8", "rsv we", {6'd0, reg_we, io_we}, 8'h00);

    // back-to-back loads, then handover to I/O clear (R9, R7, R5, R6)
    drive(1'b1, 5'h02, 3'd1, 8'h00, 8'h00);
    chk("R5", "b2b load 1", reg_out, 8'h02);
    chk("R9", "b2b we 1", {7'd0, reg_we}, 8'h01);
    drive(1'b1, 5'h02, 3'd1, 8'hFF, 8'h00);
    chk("R5", "b2b load 2", reg_out, 8'hFF);
    chk("R9", "b2b we 2", {7'd0, reg_we}, 8'h01);
    drive(1'b1, 5'h03, 3'd0, 8'h00, 8'h0F);
    chk("R7", "handover we", {6'd0, reg_we, io_we}, 8'h01);
    chk("R6", "handover io_out", io_out, 8'h0E);
    chk("R6", "handover status", status, 8'h40);

    // set an already-set flag (R2)
    drive(1'b1, 5'h0E, 3'd0, 8'h00, 8'h00);
    chk("R2", "idempotent set", status, 8'h40);

    // mid-stream reset wins over a valid operation (R1)
    drive(1'b1, 5'h0F, 3'd0, 8'h00, 8'h00);
    chk("R2", "set I", status, 8'hC0);
    rst = 1'b1;
    drive(1'b1, 5'h08, 3'd0, 8'h00, 8'h00);
    chk("R1", "midrun status", status, 8'h00);
    chk("R1", "midrun reg_out", reg_out, 8'h00);
    chk("R1", "midrun io_out", io_out, 8'h00);
    rst = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule